// File: doc/BRIEF.md
# Paged Memory Read Responder with CRC-16

This block answers a memory read request once the device has already been addressed on a serial bus. It sits on a byte-level link. Received bytes arrive as `rx_valid` pulses with `rx_byte`. The master asks for each outgoing byte with a one-cycle `tx_req` pulse, and the block answers with a one-cycle `tx_valid` pulse carrying `tx_byte`. The register memory holds 32 bytes and is read through a synchronous port: data appears on the cycle after the address is presented.

A read opens with the command byte 0xAA, followed by the low address byte and then the high address byte. The block then streams bytes from the start address up to the last byte of that 8-byte page. After the page it sends an inverted CRC-16, low byte first. For the first page the check value covers the command, the address with everything above bit 4 forced to zero, and the data sent. Each later page starts from a cleared CRC and covers only its own data. After the CRC of the top page, only 0xFF bytes are returned. A bus reset abort drops everything and returns the block to idle.

The states are:
- `ST_IDLE`: waits for the command.
- `ST_ADDR_LO` and `ST_ADDR_HI`: collect the address.
- `ST_DATA`: streams data bytes.
- `ST_CRC_LO` and `ST_CRC_HI`: send the two check bytes.
- `ST_DRAIN`: returns all ones after the map is exhausted.
- `ST_HALT`: ignores everything after a foreign command.

The transitions are:
- idle→addr_lo on 0xAA.
- idle→halt on any other byte.
- addr_lo→addr_hi and addr_hi→data on each received byte.
- data→crc_lo when the last byte of a page has been sent.
- crc_lo→crc_hi after one byte.
- crc_hi→data, or crc_hi→drain once the map has wrapped.
- Any state→idle on `bus_reset`.

Top module: `rdpg_read_resp`

## Requirements
- R1: After reset the block is idle. `tx_valid` and `mem_rd_en` stay low, and a `tx_req` in idle produces neither a memory read nor a byte.
- R2: The first received byte must be 0xAA, then come the address low byte and the address high byte. If the first byte is any other value, every later `rx_valid` and `tx_req` is ignored until `bus_reset`.
- R3: Each accepted `tx_req`, high during cycle t, yields exactly one `tx_valid` pulse in cycle t+2. Data bytes come from consecutive memory addresses, starting at the supplied address and ending at the page's last byte (address bits [2:0] = 7).
- R4: After a page's last data byte, the next two responses are the CRC, bit-inverted, low byte first. The CRC uses x^16+x^15+x^2+1 (reflected constant 0xA001), starts from zero and takes each byte LSB first.
- R5: The first page's CRC covers, in order, 0xAA, the address low byte with bits [7:5] cleared, 0x00 for the high byte, and each data byte sent.
- R6: After a page's CRC the next response is the first byte of the following page. That page's CRC starts cleared and covers only its own data.
- R7: Address bits above bit 4 (low byte [7:5] and the whole high byte) affect neither the bytes read nor the CRC.
- R8: After the CRC of the page 0x18–0x1F, every further response is 0xFF until `bus_reset`.
- R9: `bus_reset` returns the block to idle from any state, including the cycle in which a response is pending, in which case no byte is sent. A byte received in the same cycle as `bus_reset` is dropped.
- R10: A `tx_req` arriving while a response is pending is ignored. Received bytes during the read phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | Abort: return to idle |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Master requests the next byte |
| tx_valid | output | 1 | Response byte strobe |
| tx_byte | output | 8 | Response byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 5 | Memory read address |
| mem_rd_data | input | 8 | Memory data, valid the cycle after `mem_rd_en` |

## Verification
An abort and a byte transfer can land on the same clock edge. The bench provokes this in two ways:
- It raises `bus_reset` in the cycle after an accepted `tx_req`, when the memory word is already in flight. It expects no `tx_valid`.
- It pulses `bus_reset` together with an `rx_valid` carrying 0xAA, then requests bytes. Silence shows the command was dropped.

In both cases a clean read started afterwards must produce the exact byte and CRC stream, which shows the abort left no residue in the address counter or the CRC register.

// File: rtl/rdpg_pkg.sv
package rdpg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_DATA,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_DRAIN,
        ST_HALT
    } rdpg_state_e;

    // One byte into a reflected CRC-16, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [7:0]  din,
                                               input logic [15:0] poly);
        logic [15:0] c;
        c = cur;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ poly;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rdpg_crc16.sv
module rdpg_crc16 import rdpg_pkg::*; #(
    parameter logic [15:0] POLY = 16'hA001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        feed,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (feed) begin
            crc <= crc16_step(clr ? 16'h0000 : crc, din, POLY);
        end else if (clr) begin
            crc <= '0;
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !feed) |=> (crc == 16'h0000)); // R6

endmodule

// File: rtl/rdpg_addr.sv
module rdpg_addr #(
    parameter int ADDR_W = 5,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              page_end,
    output logic              wrapped
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            wrapped <= 1'b0;
        end else if (load) begin
            addr    <= load_val;
            wrapped <= 1'b0;
        end else if (inc) begin
            addr <= addr + 1'b1;
            if (&addr) wrapped <= 1'b1;
        end
    end

    assign page_end = &addr[PAGE_W-1:0];

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R3

    AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !wrapped && (&addr)) |=> wrapped); // R8

endmodule

// File: rtl/rdpg_read_resp.sv
module rdpg_read_resp import rdpg_pkg::*; #(
    parameter int          ADDR_W = 5,
    parameter int          PAGE_W = 3,
    parameter logic [7:0]  CMD    = 8'hAA,
    parameter logic [15:0] POLY   = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data
);

    localparam logic [7:0] ADDR_MASK = 8'((1 << ADDR_W) - 1);

    rdpg_state_e       state, state_nx;
    logic              pend;
    logic              accept_req, emit;
    logic              rx_ok;
    logic [ADDR_W-1:0] cur_addr;
    logic              page_end, wrapped;
    logic              a_load, a_inc;
    logic              c_clr, c_feed;
    logic [7:0]        c_din;
    logic [15:0]       crc;

    rdpg_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (a_load),
        .load_val (rx_byte[ADDR_W-1:0]),
        .inc      (a_inc),
        .addr     (cur_addr),
        .page_end (page_end),
        .wrapped  (wrapped)
    );

    rdpg_crc16 #(.POLY(POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (c_clr),
        .feed  (c_feed),
        .din   (c_din),
        .crc   (crc)
    );

    assign rx_ok = rx_valid && !bus_reset;
    assign emit  = pend && !bus_reset;

    always_comb begin
        accept_req = 1'b0;
        if (tx_req && !pend && !bus_reset) begin
            unique case (state)
                ST_DATA, ST_CRC_LO, ST_CRC_HI, ST_DRAIN: accept_req = 1'b1;
                default:                                 accept_req = 1'b0;
            endcase
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (rx_ok) state_nx = (rx_byte == CMD) ? ST_ADDR_LO : ST_HALT;
            ST_ADDR_LO: if (rx_ok) state_nx = ST_ADDR_HI;
            ST_ADDR_HI: if (rx_ok) state_nx = ST_DATA;
            ST_DATA:    if (emit && page_end) state_nx = ST_CRC_LO;
            ST_CRC_LO:  if (emit) state_nx = ST_CRC_HI;
            ST_CRC_HI:  if (emit) state_nx = wrapped ? ST_DRAIN : ST_DATA;
            ST_DRAIN:   state_nx = ST_DRAIN;
            ST_HALT:    state_nx = ST_HALT;
            default:    state_nx = ST_IDLE;
        endcase
        if (bus_reset) state_nx = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath controls
    always_comb begin
        a_load    = 1'b0;
        a_inc     = 1'b0;
        c_clr     = 1'b0;
        c_feed    = 1'b0;
        c_din     = 8'h00;
        mem_rd_en = accept_req && (state == ST_DATA);
        mem_addr  = cur_addr;
        unique case (state)
            ST_IDLE: begin
                if (rx_ok && rx_byte == CMD) begin
                    c_clr  = 1'b1;
                    c_feed = 1'b1;
                    c_din  = rx_byte;
                end
            end
            ST_ADDR_LO: begin
                if (rx_ok) begin
                    a_load = 1'b1;
                    c_feed = 1'b1;
                    c_din  = rx_byte & ADDR_MASK;
                end
            end
            ST_ADDR_HI: begin
                if (rx_ok) begin
                    c_feed = 1'b1;
                    c_din  = 8'h00;
                end
            end
            ST_DATA: begin
                if (emit) begin
                    a_inc  = 1'b1;
                    c_feed = 1'b1;
                    c_din  = mem_rd_data;
                end
            end
            ST_CRC_HI: c_clr = emit;
            default: ;
        endcase
    end

    // Registered outputs and pending flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= 8'h00;
        end else begin
            tx_valid <= emit;
            if (bus_reset)       pend <= 1'b0;
            else if (accept_req) pend <= 1'b1;
            else if (emit)       pend <= 1'b0;
            if (emit) begin
                unique case (state)
                    ST_DATA:   tx_byte <= mem_rd_data;
                    ST_CRC_LO: tx_byte <= ~crc[7:0];
                    ST_CRC_HI: tx_byte <= ~crc[15:8];
                    default:   tx_byte <= 8'hFF;
                endcase
            end
        end
    end

    AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req, 2)); // R3

    AST_TX_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid); // R10

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!tx_valid && !mem_rd_en)); // R9

    AST_READ_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        mem_rd_en |=> ##1 tx_valid); // R3

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> !tx_valid); // R2

endmodule

// File: tb/sim_rdpg_read_resp.sv
`timescale 1ns/1ps
module sim_rdpg_read_resp;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       mem_rd_en;
    logic [4:0] mem_addr;
    logic [7:0] mem_rd_data = 8'h00;

    always #4 clk = ~clk;

    rdpg_read_resp u0 (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [7:0] mem_val(input logic [4:0] a);
        return 8'({3'b000, a} * 8'd29 + 8'h41);
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(mem_addr);

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

    int total = 0, fails = 0, tx_seen = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         cyc_q[$];

    logic [4:0]  b_addr;
    logic [15:0] b_crc;
    int          b_phase;
    bit          b_wrap;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected items as bytes come out
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            tx_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected tx byte", tx_byte, 0);
            end else begin
                logic [7:0] e;
                string t;
                int c;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                c = cyc_q.pop_front();
                chk(tx_byte == e, t, tx_byte, e);
                chk(cyc == c, "R3 response cycle", cyc, c);
            end
        end
    end

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic abort();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic raw_req();
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic quiet(input string tag);
        int n;
        n = tx_seen;
        repeat (5) @(negedge clk);
        chk(tx_seen == n, tag, tx_seen, n);
    endtask

    task automatic start_read(input logic [7:0] lo, input logic [7:0] hi);
        send_rx(8'hAA); send_rx(lo); send_rx(hi);
        b_addr  = lo[4:0];
        b_crc   = bcrc(bcrc(bcrc(16'h0000, 8'hAA), {3'b000, lo[4:0]}), 8'h00);
        b_phase = 0;
        b_wrap  = 1'b0;
    endtask

    function automatic logic [7:0] model_next();
        logic [7:0] e;
        case (b_phase)
            0: begin
                e = mem_val(b_addr);
                b_crc = bcrc(b_crc, e);
                if (b_addr[2:0] == 3'd7) b_phase = 1;
                if (b_addr == 5'h1F) b_wrap = 1'b1;
                b_addr = b_addr + 1'b1;
            end
            1: begin e = ~b_crc[7:0]; b_phase = 2; end
            2: begin
                e = ~b_crc[15:8];
                b_crc = 16'h0000;
                b_phase = b_wrap ? 3 : 0;
            end
            default: e = 8'hFF;
        endcase
        return e;
    endfunction

    // Driver: pushes the expected item, then requests the byte
    task automatic pull_next(input string tag, input bit double_req = 1'b0);
        logic [7:0] e;
        e = model_next();
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag); cyc_q.push_back(cyc + 2);
        tx_req = 1'b1;
        @(negedge clk); tx_req = double_req;
        @(negedge clk); tx_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
        chk(mem_rd_en == 1'b0, "R1 mem_rd_en after reset", mem_rd_en, 0);
        @(negedge clk); tx_req = 1'b1;
        #1 chk(mem_rd_en == 1'b0, "R1 no read in idle", mem_rd_en, 0);
        @(negedge clk); tx_req = 1'b0;
        quiet("R1 idle request silent");

        // Mid-page start, first page CRC, then a full second page
        start_read(8'h03, 8'h00);
        for (int i = 0; i < 5; i++) pull_next("R3 data from start address");
        pull_next("R5 first page CRC low");
        pull_next("R4 first page CRC high");
        for (int i = 0; i < 8; i++) pull_next("R6 next page data");
        pull_next("R6 later page CRC low");
        pull_next("R6 later page CRC high");
        abort();

        // High address bits ignored, top page then all ones
        start_read(8'hFD, 8'h12);
        for (int i = 0; i < 3; i++) pull_next("R7 masked address data");
        pull_next("R7 CRC with masked address low");
        pull_next("R7 CRC with masked address high");
        for (int i = 0; i < 3; i++) pull_next("R8 drain ones");
        abort();

        // Foreign command
        send_rx(8'h55);
        send_rx(8'hAA);
        raw_req(); raw_req();
        quiet("R2 foreign command silent");
        abort();
        start_read(8'h10, 8'h00);
        for (int i = 0; i < 10; i++) pull_next("R9 read after abort");
        abort();

        // Abort while a response is pending
        start_read(8'h00, 8'h00);
        pull_next("R9 byte before abort");
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0; bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        quiet("R9 pending response dropped");
        // Abort together with a command byte
        @(negedge clk); bus_reset = 1'b1; rx_valid = 1'b1; rx_byte = 8'hAA;
        @(negedge clk); bus_reset = 1'b0; rx_valid = 1'b0;
        raw_req();
        quiet("R9 command in abort cycle dropped");

        // Double request and stray received bytes
        start_read(8'h18, 8'h00);
        pull_next("R10 first byte");
        pull_next("R10 double request gives one byte", 1'b1);
        send_rx(8'hAA);
        send_rx(8'h05);
        for (int i = 0; i < 8; i++) pull_next("R10 stream after stray rx");
        abort();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all expected bytes delivered", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule